// File: doc/BRIEF.md
# Register-Mapped Flash Access Controller

This block gives a debug host byte-level access to an on-chip flash array through a small register bus. The host selects one of four registers: a control register, a 16-bit address register, a data register and a read-only status register. The control register holds two 4-bit mode fields. One field governs host writes to the data register and the other governs host reads of it. Depending on those fields, a data-register access either just moves a byte or also starts a flash operation at the current address. The operation can be a byte program, a page erase, a whole-user-area erase or a byte read.

A started operation holds the busy flag for a fixed number of cycles. For an erase, the flag stays high for one cycle per byte cleared. The address register steps by one after every program and every read, so the host can stream bytes in or out without rewriting the address. The flash is modelled by an internal byte array that can be inferred as block RAM. With default parameters the array has 2048 bytes in 512-byte pages. The last page is reserved, so the user area ends at 0x5FF.

Top module: `flash_access_ctrl`

## Requirements
- R1: After reset the control, address and data registers and the status register all read 0 and `busy` is low. Register select codes are 0 control, 1 address, 2 data, 3 status.
- R2: With write-mode field (control bits 7..4) equal to 0, a data write only loads the data register. It starts nothing, leaves the address unchanged and leaves the flash unchanged.
- R3: With write mode 1 and `busy` low, a data write loads the data register and programs the addressed byte as old AND new. `busy` is high for exactly OP_CYCLES cycles, and then the address has increased by one.
- R4: With write mode 2 and `busy` low, a data write of 0xA5 erases to 0xFF the 512-byte page holding the address. `busy` is high for 512 cycles and the address is left unchanged. Any other data byte starts nothing.
- R5: An erase requested while the address is 0x5FE or 0x5FF clears every byte from 0 to 0x5FF, holding `busy` for 1536 cycles. The reserved page 0x600..0x7FF keeps its contents.
- R6: With read-mode field (control bits 3..0) equal to 0, a data read returns the data register and has no other effect.
- R7: With read mode 1 and `busy` low, a data read returns the current data register and starts a flash read. After OP_CYCLES cycles, the addressed byte is in the data register and the address has increased by one.
- R8: With read mode 2, a data read starts a flash read only if `busy` is low and the last fetched byte has already been read by the host. Any host data read marks the byte as consumed. Status bit 1 shows an unconsumed byte.
- R9: Write-mode and read-mode values other than 0, 1 and 2 start no operation. Such a data write still loads the data register.
- R10: While `busy` is high, a data write in write mode 1 or 2 is ignored completely, and a data read starts nothing.
- R11: A host write to the address register in the same cycle as a program or read completes wins over the automatic increment.
- R12: `reg_rdata` is registered. It shows the selected register one cycle after `reg_rd` and holds its value while `reg_rd` is low. Status bit 0 is `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select (0 control, 1 address, 2 data, 3 status) |
| reg_wdata | input | ADDR_W | Write data; control and data use the low byte |
| reg_rdata | output | ADDR_W | Registered read data |
| busy | output | 1 | A flash operation is in progress |

## Verification
The address register has two writers. The host can write it over the bus, and the end of a program or read operation increments it. The bench counts the cycles from the data write that starts a program. It then places a host address write exactly on the completion edge and expects the host value, not the host value plus one and not the old address plus one. A second overlap is a host data read on the edge where a fetched byte lands. The cycle model judges this through the status unconsumed bit and the value returned.

// File: rtl/fac_pkg.sv
package fac_pkg;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam logic [3:0] WR_PASSIVE = 4'd0;
  localparam logic [3:0] WR_PROGRAM = 4'd1;
  localparam logic [3:0] WR_ERASE   = 4'd2;

  localparam logic [3:0] RD_PASSIVE = 4'd0;
  localparam logic [3:0] RD_STREAM  = 4'd1;
  localparam logic [3:0] RD_SINGLE  = 4'd2;

  localparam logic [7:0] ERASE_KEY = 8'hA5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_READ  = 2'd3
  } op_kind_t;

endpackage

// File: rtl/fac_launch_decode.sv
module fac_launch_decode
  import fac_pkg::*;
(
  input  logic       acc_wr,
  input  logic       acc_rd,
  input  logic [1:0] sel,
  input  logic [7:0] wbyte,
  input  logic [3:0] wr_mode,
  input  logic [3:0] rd_mode,
  input  logic       busy,
  input  logic       unread,
  output logic       launch,
  output op_kind_t   launch_kind,
  output logic       data_wr_en,
  output logic       consume
);

  logic data_w, data_r;

  assign data_w  = acc_wr && (sel == SEL_DATA);
  assign data_r  = acc_rd && (sel == SEL_DATA);
  assign consume = data_r;

  always_comb begin
    launch_kind = OP_NONE;
    data_wr_en  = 1'b0;
    if (data_w) begin
      case (wr_mode)
        WR_PASSIVE: data_wr_en = 1'b1;
        WR_PROGRAM: begin
          if (!busy) begin
            data_wr_en  = 1'b1;
            launch_kind = OP_PROG;
          end
        end
        WR_ERASE: begin
          if (!busy) begin
            data_wr_en = 1'b1;
            if (wbyte == ERASE_KEY) launch_kind = OP_ERASE;
          end
        end
        default: data_wr_en = 1'b1;
      endcase
    end
    if (data_r && (launch_kind == OP_NONE)) begin
      case (rd_mode)
        RD_STREAM: if (!busy) launch_kind = OP_READ;
        RD_SINGLE: if (!busy && !unread) launch_kind = OP_READ;
        default: ;
      endcase
    end
  end

  assign launch = (launch_kind != OP_NONE);

endmodule

// File: rtl/fac_byte_array.sv
module fac_byte_array #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);

  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] cells [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wbyte;
    rbyte <= cells[idx];
  end

endmodule

// File: rtl/fac_op_engine.sv
module fac_op_engine
  import fac_pkg::*;
#(
  parameter int              AW         = 16,
  parameter int              FLASH_AW   = 11,
  parameter int              PAGE_AW    = 9,
  parameter int              LAT        = 4,
  parameter int              RSVD_BASE  = 1536,
  parameter logic [AW-1:0]   MASS_ADDR  = 16'h05FE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch,
  input  op_kind_t            launch_kind,
  input  logic [AW-1:0]       launch_addr,
  input  logic [7:0]          launch_byte,
  input  logic [7:0]          mem_rbyte,
  output logic                busy,
  output logic                done,
  output op_kind_t            done_kind,
  output logic                mem_we,
  output logic [FLASH_AW-1:0] mem_idx,
  output logic [7:0]          mem_wbyte
);

  localparam int CW         = FLASH_AW + 1;
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  logic                busy_q;
  op_kind_t            kind_q;
  logic [CW-1:0]       cnt_q, last_q;
  logic [FLASH_AW-1:0] op_idx_q, base_q;
  logic [7:0]          byte_q;
  logic                final_c, mass_c;

  assign final_c = busy_q && (cnt_q == last_q);
  assign mass_c  = (launch_addr[AW-1:1] == MASS_ADDR[AW-1:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      kind_q   <= OP_NONE;
      cnt_q    <= '0;
      last_q   <= '0;
      op_idx_q <= '0;
      base_q   <= '0;
      byte_q   <= '0;
    end else if (launch && !busy_q) begin
      busy_q   <= 1'b1;
      kind_q   <= launch_kind;
      cnt_q    <= '0;
      byte_q   <= launch_byte;
      op_idx_q <= launch_addr[FLASH_AW-1:0];
      if (launch_kind == OP_ERASE) begin
        if (mass_c) begin
          base_q <= '0;
          last_q <= CW'(RSVD_BASE - 1);
        end else begin
          base_q <= {launch_addr[FLASH_AW-1:PAGE_AW], {PAGE_AW{1'b0}}};
          last_q <= CW'(PAGE_BYTES - 1);
        end
      end else begin
        last_q <= CW'(LAT - 1);
      end
    end else if (busy_q) begin
      if (final_c) busy_q <= 1'b0;
      else         cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy      = busy_q;
  assign done      = final_c;
  assign done_kind = kind_q;

  always_comb begin
    if (kind_q == OP_ERASE) begin
      mem_idx   = base_q + cnt_q[FLASH_AW-1:0];
      mem_wbyte = 8'hFF;
      mem_we    = busy_q;
    end else begin
      mem_idx   = op_idx_q;
      mem_wbyte = mem_rbyte & byte_q;
      mem_we    = final_c && (kind_q == OP_PROG);
    end
  end

endmodule

// File: rtl/fac_host_regs.sv
module fac_host_regs
  import fac_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  input  logic          data_wr_en,
  input  logic          consume,
  input  logic          done,
  input  op_kind_t      done_kind,
  input  logic [7:0]    done_byte,
  input  logic          busy,
  output logic [7:0]    ctrl_q,
  output logic [AW-1:0] addr_q,
  output logic [7:0]    data_q,
  output logic          unread_q,
  output logic [AW-1:0] rdata
);

  logic steps_addr, fetch_done;

  assign fetch_done = done && (done_kind == OP_READ);
  assign steps_addr = done && ((done_kind == OP_PROG) || (done_kind == OP_READ));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      unread_q <= 1'b0;
      rdata    <= '0;
    end else begin
      if (acc_rd) begin
        case (sel)
          SEL_CTRL: rdata <= AW'(ctrl_q);
          SEL_ADDR: rdata <= addr_q;
          SEL_DATA: rdata <= AW'(data_q);
          default:  rdata <= AW'({unread_q, busy});
        endcase
      end
      if (acc_wr && (sel == SEL_CTRL)) ctrl_q <= wdata[7:0];
      if (acc_wr && (sel == SEL_ADDR))  addr_q <= wdata;
      else if (steps_addr)              addr_q <= addr_q + 1'b1;
      if (data_wr_en)      data_q <= wdata[7:0];
      else if (fetch_done) data_q <= done_byte;
      if (fetch_done)      unread_q <= 1'b1;
      else if (consume)    unread_q <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_access_ctrl.sv
module flash_access_ctrl
  import fac_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int FLASH_AW   = 11,
  parameter int PAGE_AW    = 9,
  parameter int RSVD_BYTES = 512,
  parameter int OP_CYCLES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              busy
);

  localparam int               FLASH_BYTES = 1 << FLASH_AW;
  localparam int               RSVD_BASE   = FLASH_BYTES - RSVD_BYTES;
  localparam logic [ADDR_W-1:0] MASS_ADDR  = ADDR_W'(RSVD_BASE - 2);
  localparam int               LAT         = (OP_CYCLES < 2) ? 2 : OP_CYCLES;

  logic [7:0]          ctrl_q, data_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                unread_q;
  logic                launch, data_wr_en, consume, done;
  op_kind_t            launch_kind, done_kind;
  logic                mem_we;
  logic [FLASH_AW-1:0] mem_idx;
  logic [7:0]          mem_wbyte, mem_rbyte;
  logic [3:0]          wr_mode;

  assign wr_mode = ctrl_q[7:4];

  fac_launch_decode u_decode (
    .acc_wr      (reg_wr),
    .acc_rd      (reg_rd),
    .sel         (reg_sel),
    .wbyte       (reg_wdata[7:0]),
    .wr_mode     (wr_mode),
    .rd_mode     (ctrl_q[3:0]),
    .busy        (busy),
    .unread      (unread_q),
    .launch      (launch),
    .launch_kind (launch_kind),
    .data_wr_en  (data_wr_en),
    .consume     (consume)
  );

  fac_host_regs #(.AW(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .acc_wr     (reg_wr),
    .acc_rd     (reg_rd),
    .sel        (reg_sel),
    .wdata      (reg_wdata),
    .data_wr_en (data_wr_en),
    .consume    (consume),
    .done       (done),
    .done_kind  (done_kind),
    .done_byte  (mem_rbyte),
    .busy       (busy),
    .ctrl_q     (ctrl_q),
    .addr_q     (addr_q),
    .data_q     (data_q),
    .unread_q   (unread_q),
    .rdata      (reg_rdata)
  );

  fac_op_engine #(
    .AW        (ADDR_W),
    .FLASH_AW  (FLASH_AW),
    .PAGE_AW   (PAGE_AW),
    .LAT       (LAT),
    .RSVD_BASE (RSVD_BASE),
    .MASS_ADDR (MASS_ADDR)
  ) u_engine (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch),
    .launch_kind (launch_kind),
    .launch_addr (addr_q),
    .launch_byte (reg_wdata[7:0]),
    .mem_rbyte   (mem_rbyte),
    .busy        (busy),
    .done        (done),
    .done_kind   (done_kind),
    .mem_we      (mem_we),
    .mem_idx     (mem_idx),
    .mem_wbyte   (mem_wbyte)
  );

  fac_byte_array #(.IDX_W(FLASH_AW)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .idx   (mem_idx),
    .wbyte (mem_wbyte),
    .rbyte (mem_rbyte)
  );

endmodule

// File: rtl/fac_checker.sv
module fac_checker
  import fac_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [1:0]    reg_sel,
  input logic [AW-1:0] reg_wdata,
  input logic [AW-1:0] reg_rdata,
  input logic          busy,
  input logic [3:0]    wr_mode,
  input logic [AW-1:0] addr_q,
  input logic          unread_q,
  input logic          done,
  input op_kind_t      done_kind
);

  logic host_addr_wr;
  assign host_addr_wr = reg_wr && (reg_sel == SEL_ADDR);

  AST_PROG_STEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (done && done_kind == OP_PROG && !host_addr_wr) |=> addr_q == $past(addr_q) + 1'b1); // R3

  AST_READ_STEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (done && done_kind == OP_READ && !host_addr_wr) |=> addr_q == $past(addr_q) + 1'b1); // R7

  AST_ERASE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (done && done_kind == OP_ERASE && !host_addr_wr) |=> addr_q == $past(addr_q)); // R4

  AST_HOST_ADDR_WINS: assert property (@(posedge clk) disable iff (rst)
    host_addr_wr |=> addr_q == $past(reg_wdata)); // R11

  AST_PASSIVE_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_rd && reg_sel == SEL_DATA && wr_mode == WR_PASSIVE && !busy) |=> !busy); // R2

  AST_BUSY_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(reg_sel) == SEL_DATA && $past(reg_wr || reg_rd))); // R9

  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R10

  AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel == SEL_DATA && !done) |=> !unread_q); // R8

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata)); // R12

endmodule

bind flash_access_ctrl fac_checker #(.AW(ADDR_W)) u_fac_checker (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .busy      (busy),
  .wr_mode   (wr_mode),
  .addr_q    (addr_q),
  .unread_q  (unread_q),
  .done      (done),
  .done_kind (done_kind)
);

// File: tb/test_flash_access_ctrl.sv
module test_flash_access_ctrl;

  localparam int OPC  = 4;
  localparam int PAGE = 512;
  localparam int USER = 1536;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  flash_access_ctrl i_flash_access_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
  );

  // ---------------- behavioural reference model ----------------
  int  m_ctrl, m_addr, m_data, m_unread, m_busy, m_left, m_kind, m_opaddr, m_opbyte, m_rdata;
  byte unsigned m_mem [0:2047];
  // kinds: 0 none, 1 program, 2 erase, 3 read

  initial for (int i = 0; i < 2048; i++) m_mem[i] = 8'hFF;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_addr = 0; m_data = 0; m_unread = 0;
      m_busy = 0; m_left = 0; m_kind = 0; m_rdata = 0;
    end else begin
      int  start, wmode, rmode, base, cnt;
      bit  done_now, host_data;
      done_now  = (m_busy == 1) && (m_left == 1);
      start     = 0;
      host_data = 0;
      wmode = (m_ctrl >> 4) & 15;
      rmode = m_ctrl & 15;
      if (reg_rd) begin
        case (reg_sel)
          2'd0: m_rdata = m_ctrl;
          2'd1: m_rdata = m_addr;
          2'd2: m_rdata = m_data;
          default: m_rdata = m_unread * 2 + m_busy;
        endcase
      end
      if (reg_wr && reg_sel == 2'd2) begin
        if (wmode == 1 || wmode == 2) begin
          if (!m_busy) begin
            m_data = reg_wdata & 255; host_data = 1;
            if (wmode == 1) start = 1;
            else if ((reg_wdata & 255) == 8'hA5) start = 2;
          end
        end else begin
          m_data = reg_wdata & 255; host_data = 1;
        end
      end
      if (reg_rd && reg_sel == 2'd2 && start == 0 && !m_busy) begin
        if (rmode == 1 || (rmode == 2 && !m_unread)) start = 3;
      end
      if (reg_rd && reg_sel == 2'd2) m_unread = 0;
      if (reg_wr && reg_sel == 2'd0) m_ctrl = reg_wdata & 255;
      if (done_now) begin
        if (m_kind == 1) m_mem[m_opaddr & 2047] = m_mem[m_opaddr & 2047] & m_opbyte;
        if (m_kind == 3) begin
          if (!host_data) m_data = m_mem[m_opaddr & 2047];
          m_unread = 1;
        end
        if (m_kind == 2) begin
          if ((m_opaddr >> 1) == (16'h05FE >> 1)) begin base = 0; cnt = USER; end
          else begin base = (m_opaddr & 2047) & ~(PAGE - 1); cnt = PAGE; end
          for (int k = 0; k < cnt; k++) m_mem[base + k] = 8'hFF;
        end
        if (m_kind == 1 || m_kind == 3) m_addr = (m_addr + 1) & 16'hFFFF;
        m_busy = 0;
      end else if (m_busy) begin
        m_left = m_left - 1;
      end
      if (reg_wr && reg_sel == 2'd1) m_addr = reg_wdata;
      if (start != 0) begin
        m_busy = 1; m_kind = start; m_opaddr = m_addr; m_opbyte = reg_wdata & 255;
        if (start == 2) m_left = (((m_addr >> 1) == (16'h05FE >> 1)) ? USER : PAGE);
        else m_left = OPC;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !ended) begin
      string bt;
      case (m_kind)
        1: bt = "R3"; 2: bt = "R4"; 3: bt = "R7"; default: bt = "R10";
      endcase
      chk({bt, " busy vs model"}, busy, m_busy);
      chk("R12 rdata vs model", reg_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic acc(input bit w, input bit r, input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] s, input logic [15:0] v);
    acc(1'b1, 1'b0, s, v);
  endtask

  task automatic rreg(input logic [1:0] s, output logic [15:0] v);
    acc(1'b0, 1'b1, s, 16'h0);
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic program_at(input logic [15:0] a, input logic [7:0] b);
    wreg(2'd0, 16'h0010);
    wreg(2'd1, a);
    wreg(2'd2, {8'h00, b});
    wait_idle();
  endtask

  task automatic peek(input logic [15:0] a, output logic [15:0] v);
    logic [15:0] junk;
    wreg(2'd0, 16'h0001);
    wreg(2'd1, a);
    rreg(2'd2, junk);
    wait_idle();
    wreg(2'd0, 16'h0000);
    rreg(2'd2, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 busy after reset", busy, 0);
    rreg(2'd0, v); chk("R1 control", v, 0);
    rreg(2'd1, v); chk("R1 address", v, 0);
    rreg(2'd2, v); chk("R1 data", v, 0);
    rreg(2'd3, v); chk("R1 status", v, 0);

    // R2 / R6 passive modes
    wreg(2'd2, 16'h003C);
    chk("R2 no busy", busy, 0);
    rreg(2'd2, v); chk("R6 data readback", v, 16'h3C);
    rreg(2'd1, v); chk("R2 address kept", v, 0);
    chk("R6 no busy after read", busy, 0);

    // bring the array to a known state: user area, then reserved page
    wreg(2'd0, 16'h0020);
    wreg(2'd1, 16'h05FE);
    wreg(2'd2, 16'h00A5);
    wait_idle();
    wreg(2'd1, 16'h0600);
    wreg(2'd2, 16'h00A5);
    wait_idle();

    // R3 program with AND and increment
    program_at(16'h0010, 8'h5A);
    rreg(2'd1, v); chk("R3 address stepped", v, 16'h0011);
    wreg(2'd2, 16'h000F);
    chk("R3 busy raised", busy, 1);
    repeat (OPC - 1) @(negedge clk);
    chk("R3 busy at last cycle", busy, 1);
    @(negedge clk);
    chk("R3 busy dropped", busy, 0);
    program_at(16'h0010, 8'hF0);

    // R7 streaming reads
    wreg(2'd0, 16'h0001);
    wreg(2'd1, 16'h0010);
    rreg(2'd2, v);
    wait_idle();
    rreg(2'd2, v); chk("R7 first byte", v, 16'h50);
    rreg(2'd1, v); chk("R7 address mid-stream", v, 16'h0011);
    wait_idle();
    rreg(2'd2, v); chk("R7 second byte", v, 16'h0F);
    wait_idle();

    // R8 single reads
    wreg(2'd0, 16'h0002);
    wreg(2'd1, 16'h0010);
    rreg(2'd3, v); chk("R8 unread set", v, 16'h2);
    rreg(2'd2, v); chk("R8 consuming read", v, 16'hFF);
    chk("R8 consuming read starts nothing", busy, 0);
    rreg(2'd2, v);
    chk("R8 fresh read launches", busy, 1);
    wait_idle();
    rreg(2'd2, v); chk("R8 fetched byte", v, 16'h50);
    chk("R8 no surplus read", busy, 0);
    rreg(2'd3, v); chk("R8 status after consume", v, 0);
    rreg(2'd1, v); chk("R8 address", v, 16'h0011);

    // R10 writes ignored while busy
    wreg(2'd0, 16'h0010);
    wreg(2'd1, 16'h0020);
    wreg(2'd2, 16'h0000);
    wreg(2'd2, 16'h0077);
    wait_idle();
    rreg(2'd2, v); chk("R10 data unchanged", v, 0);
    rreg(2'd1, v); chk("R10 single increment", v, 16'h0021);

    // R4 page erase
    program_at(16'h0200, 8'h11);
    program_at(16'h0100, 8'h11);
    program_at(16'h0700, 8'h11);
    wreg(2'd0, 16'h0020);
    wreg(2'd1, 16'h02AB);
    wreg(2'd2, 16'h0012);
    chk("R4 wrong key ignored", busy, 0);
    wreg(2'd2, 16'h00A5);
    repeat (PAGE - 2) @(negedge clk);
    chk("R4 busy through page", busy, 1);
    wait_idle();
    rreg(2'd1, v); chk("R4 address unchanged", v, 16'h02AB);
    peek(16'h0200, v); chk("R4 page cleared", v, 16'hFF);
    peek(16'h0100, v); chk("R4 other page kept", v, 16'h11);

    // R5 mass erase
    wreg(2'd0, 16'h0020);
    wreg(2'd1, 16'h05FF);
    wreg(2'd2, 16'h00A5);
    repeat (1000) @(negedge clk);
    chk("R5 busy beyond a page", busy, 1);
    wait_idle();
    peek(16'h0100, v); chk("R5 user byte cleared", v, 16'hFF);
    peek(16'h0010, v); chk("R5 low byte cleared", v, 16'hFF);
    peek(16'h0700, v); chk("R5 reserved kept", v, 16'h11);

    // R9 reserved modes
    wreg(2'd0, 16'h0033);
    wreg(2'd2, 16'h00A5);
    chk("R9 reserved write no op", busy, 0);
    rreg(2'd2, v); chk("R9 data loaded", v, 16'hA5);
    chk("R9 reserved read no op", busy, 0);
    wreg(2'd0, 16'h00F3);
    wreg(2'd2, 16'h005A);
    rreg(2'd3, v); chk("R9 status idle", v, 0);

    // R11 host address write on completion edge
    wreg(2'd0, 16'h0010);
    wreg(2'd1, 16'h0030);
    wreg(2'd2, 16'h006C);
    repeat (OPC - 2) @(negedge clk);
    wreg(2'd1, 16'h0040);
    chk("R11 completion edge", busy, 0);
    rreg(2'd1, v); chk("R11 host address wins", v, 16'h0040);
    peek(16'h0030, v); chk("R11 program landed", v, 16'h6C);

    // R12 rdata holds between reads
    rreg(2'd0, v);
    repeat (3) @(negedge clk);
    chk("R12 rdata held", reg_rdata, v);

    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule